// File: doc/BRIEF.md
# System Clock Source Switch with Crystal-Loss Fallback

This block picks the system clock from three sources: an internal RC oscillator, an external crystal oscillator, and a PLL output. Each source has an enable bit and a ready flag. Software turns a source on, polls until its ready flag rises, then requests it as the system clock. A request is taken only when the target source is ready. The switch over is glitch-free: the old clock is gated off on its own falling edge before the new one is gated on.

A monitor can watch the crystal clock. It counts internal-clock cycles between crystal edges. If the crystal stops while the system clock depends on it, the block flags the failure, raises an interrupt and moves the system clock back to the internal RC clock. The block also holds the PLL reference and multiplier fields, and drives a clock-output pin through a four-way selector. All control logic runs on the internal RC clock, which is also the clock of the register port.

The register port is a plain write strobe with an address bit and a combinational read-back. It has no valid/ready handshake and never stalls, so back-pressure does not arise. Every write is taken on the next `clk_rc` edge.

Top module: `sysclk_switch`

## Requirements
- R1: `src_status` gives the source in use: 0 = internal RC, 1 = crystal, 2 = PLL. A config write (address 1) whose bits [1:0] name a ready source changes `src_status` at the next `clk_rc` edge. Once the switch completes, `sys_clk` runs at that source's frequency.
- R2: Control word (address 0) layout: enables at bits [2:0] (RC, crystal, PLL), monitor enable at bit 3, ready flags at bits [6:4], failure flag at bit 8. A ready flag rises only after its source has run SETTLE_CYC cycles with the enable set. It reads low from the clock after its enable is cleared.
- R3: A request for a source whose ready flag is low, or for code 3, is ignored, and `src_status` keeps its value.
- R4: The crystal counts as failed when no crystal edge is seen for FAIL_TIMEOUT internal-clock cycles. This check runs only while both the monitor enable and the crystal enable are set.
- R5: A failure clears the crystal enable. If the system clock was taken from the crystal, directly or through a PLL with a crystal-based reference, the block forces the RC enable on and sets `src_status` to 0. `sys_clk` then runs at the RC frequency.
- R6: A failure sets a sticky flag, seen on `fail_irq` and at control bit 8. Only a control write with bit 8 set clears it.
- R7: At most one source gate is open at any time. The system clock shows no extra pulses across a switch.
- R8: A write that would clear the enable of a source now driving the system clock, directly or as the PLL reference, leaves that enable set.
- R9: Config bits [3:2] set the PLL reference: 0 = RC/2, 1 = crystal, 2 = crystal/2. Bits [7:4] set the multiplier code, where code c means a factor of c+2. Reference code 3 and multiplier code 15 leave their field unchanged. The fields appear on `pll_ref` and `pll_mul`.
- R10: Config bits [9:8] select what `clk_out` carries: 0 = system clock, 1 = RC clock, 2 = crystal clock, 3 = PLL clock divided by two.
- R11: After reset, only the RC enable is set, `src_status` is 0, the failure flag is clear and all config fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC clock; also the control and register clock |
| clk_xtal | input | 1 | External crystal clock |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = config word |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| sys_clk | output | 1 | Selected system clock |
| src_status | output | 2 | Source in use |
| fail_irq | output | 1 | Crystal failure flag / interrupt |
| clk_out | output | 1 | Clock-output pin signal |
| pll_ref | output | 2 | PLL reference choice |
| pll_mul | output | 4 | PLL multiplier code |

## Verification
A wrong selection register shows on `src_status` at the first `clk_rc` edge after the faulty write. A wrong gate state shows within a few source cycles as a wrong edge count on `sys_clk` or `clk_out`. A ready flag that is stuck, or that rises too early, shows in the control read-back right after an enable change or a settle wait. A failure detector that is missing, or that fires when it should not, leaves `fail_irq` and `src_status` wrong about a dozen internal cycles after the crystal stops.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/src_ready.sv
module src_ready #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk_ctl,
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_i,
  output logic rdy_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [1:0]    en_sync;
  logic [CW-1:0] cnt;
  logic          done;
  logic [1:0]    rdy_sync;
  logic          armed;

  // source domain: settle counter restarts whenever the enable is seen low
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      en_sync <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      en_sync <= {en_sync[0], en_i};
      if (!en_sync[1]) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (!done) begin
        if (cnt == CW'(SETTLE_CYC - 1)) done <= 1'b1;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // control domain: a stale "done" must be seen low once before it counts again
  always_ff @(posedge clk_ctl or negedge rst_n) begin
    if (!rst_n) begin
      rdy_sync <= '0;
      armed    <= 1'b0;
    end else begin
      rdy_sync <= {rdy_sync[0], done};
      if (!en_i)             armed <= 1'b0;
      else if (!rdy_sync[1]) armed <= 1'b1;
    end
  end

  assign rdy_o = en_i & armed & rdy_sync[1];

  AST_RDY_AFTER_ARM: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $rose(rdy_o) |-> $past(en_i)); // R2
endmodule

// File: rtl/xtal_mon.sv
module xtal_mon #(
  parameter int TIMEOUT = 8
) (
  input  logic clk_ctl,
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic active_i,
  output logic fail_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          tgl;
  logic [2:0]    tsync;
  logic          edge_seen;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  always_ff @(posedge clk_ctl or negedge rst_n) begin
    if (!rst_n) tsync <= '0;
    else        tsync <= {tsync[1:0], tgl};
  end

  assign edge_seen = tsync[2] ^ tsync[1];

  always_ff @(posedge clk_ctl or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fail_o <= 1'b0;
    end else begin
      fail_o <= 1'b0;
      if (!active_i || edge_seen) begin
        cnt <= '0;
      end else if (cnt == CW'(TIMEOUT - 1)) begin
        cnt    <= '0;
        fail_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_FAIL_ONE_PULSE: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    fail_o |=> !fail_o); // R4
  AST_FAIL_NEEDS_ACTIVE: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    fail_o |-> $past(active_i)); // R4
endmodule

// File: rtl/gf_clk_mux.sv
module gf_clk_mux #(
  parameter int N = 3
) (
  input  logic [N-1:0] src_clk,
  input  logic         clk_ctl,
  input  logic         rst_n,
  input  logic [N-1:0] sel_oh,
  input  logic [N-1:0] kill_n,
  output logic         clk_o
);
  logic [N-1:0] gen_q;
  logic [N-1:0] gclk;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic RV = (i == 0) ? 1'b1 : 1'b0;
    logic others, req, s1, s2, g, arst_n;

    assign others = |(gen_q & ~(N'(1) << i));
    assign req    = sel_oh[i] & ~others;
    assign arst_n = rst_n & kill_n[i];

    always_ff @(posedge src_clk[i] or negedge arst_n) begin
      if (!arst_n) begin
        s1 <= RV;
        s2 <= RV;
      end else begin
        s1 <= req;
        s2 <= s1;
      end
    end

    // gate changes only while this source is low
    always_ff @(negedge src_clk[i] or negedge arst_n) begin
      if (!arst_n) g <= RV;
      else         g <= s2;
    end

    assign gen_q[i] = g;
    assign gclk[i]  = src_clk[i] & g;
  end

  assign clk_o = |gclk;

  AST_ONE_GATE_OPEN: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $onehot0(gen_q)); // R7
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int DW           = 10,
  parameter int SETTLE_CYC   = 16,
  parameter int FAIL_TIMEOUT = 8
) (
  input  logic          clk_rc,
  input  logic          clk_xtal,
  input  logic          clk_pll,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sys_clk,
  output logic [1:0]    src_status,
  output logic          fail_irq,
  output logic          clk_out,
  output logic [1:0]    pll_ref,
  output logic [3:0]    pll_mul
);
  localparam logic [1:0] REF_BAD = 2'd3;
  localparam logic [3:0] MUL_BAD = 4'd15;

  logic [NUM_SRC-1:0] src_clk, rdy, en_q, keep, sel_oh, kill_n;
  logic [3:0]         rdy4;
  logic               mon_en, fail_q, fail_evt, pll_half;
  logic [1:0]         ref_q, osel_q;
  logic [3:0]         mul_q;
  src_e               cur_sel, req;
  logic               wr_ctl, wr_cfg, req_ok, pll_on_rc, xtal_based;

  assign src_clk = {clk_pll, clk_xtal, clk_rc};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rdy
    src_ready #(.SETTLE_CYC(SETTLE_CYC)) u_rdy (
      .clk_ctl (clk_rc),
      .clk_src (src_clk[i]),
      .rst_n   (rst_n),
      .en_i    (en_q[i]),
      .rdy_o   (rdy[i])
    );
  end

  xtal_mon #(.TIMEOUT(FAIL_TIMEOUT)) u_mon (
    .clk_ctl  (clk_rc),
    .clk_xtal (clk_xtal),
    .rst_n    (rst_n),
    .active_i (mon_en & en_q[SRC_XTAL]),
    .fail_o   (fail_evt)
  );

  assign sel_oh = NUM_SRC'(1) << cur_sel;
  assign kill_n = {en_q[SRC_PLL], en_q[SRC_XTAL], 1'b1};

  gf_clk_mux #(.N(NUM_SRC)) u_mux (
    .src_clk (src_clk),
    .clk_ctl (clk_rc),
    .rst_n   (rst_n),
    .sel_oh  (sel_oh),
    .kill_n  (kill_n),
    .clk_o   (sys_clk)
  );

  // decode and protection
  assign wr_ctl     = reg_wr && !reg_addr;
  assign wr_cfg     = reg_wr && reg_addr;
  assign rdy4       = {1'b0, rdy};
  assign req        = src_e'(reg_wdata[1:0]);
  assign req_ok     = rdy4[reg_wdata[1:0]];
  assign pll_on_rc  = (ref_q == 2'd0);
  assign xtal_based = (cur_sel == SRC_XTAL) || (cur_sel == SRC_PLL && !pll_on_rc);
  assign keep[SRC_RC]   = (cur_sel == SRC_RC) || (cur_sel == SRC_PLL && pll_on_rc);
  assign keep[SRC_XTAL] = xtal_based;
  assign keep[SRC_PLL]  = (cur_sel == SRC_PLL);

  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= NUM_SRC'(1);
      mon_en  <= 1'b0;
      fail_q  <= 1'b0;
      cur_sel <= SRC_RC;
      ref_q   <= '0;
      mul_q   <= '0;
      osel_q  <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= reg_wdata[NUM_SRC-1:0] | keep;
        mon_en <= reg_wdata[3];
        if (reg_wdata[8]) fail_q <= 1'b0;
      end
      if (wr_cfg) begin
        if (req_ok) cur_sel <= req;
        if (reg_wdata[3:2] != REF_BAD) ref_q <= reg_wdata[3:2];
        if (reg_wdata[7:4] != MUL_BAD) mul_q <= reg_wdata[7:4];
        osel_q <= reg_wdata[9:8];
      end
      if (fail_evt) begin
        fail_q         <= 1'b1;
        en_q[SRC_XTAL] <= 1'b0;
        if (xtal_based) begin
          cur_sel      <= SRC_RC;
          en_q[SRC_RC] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_pll or negedge rst_n) begin
    if (!rst_n) pll_half <= 1'b0;
    else        pll_half <= ~pll_half;
  end

  always_comb begin
    case (osel_q)
      2'd0:    clk_out = sys_clk;
      2'd1:    clk_out = clk_rc;
      2'd2:    clk_out = clk_xtal;
      default: clk_out = pll_half;
    endcase
  end

  assign reg_rdata  = reg_addr ? DW'({osel_q, mul_q, ref_q, cur_sel})
                               : DW'({fail_q, 1'b0, rdy, mon_en, en_q});
  assign src_status = cur_sel;
  assign fail_irq   = fail_q;
  assign pll_ref    = ref_q;
  assign pll_mul    = mul_q;

  AST_REQ_TAKEN: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (wr_cfg && !fail_evt && rdy4[reg_wdata[1:0]]) |=> (src_status == $past(reg_wdata[1:0]))); // R1
  AST_REQ_NOT_READY: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (wr_cfg && !fail_evt && !rdy4[reg_wdata[1:0]]) |=> $stable(src_status)); // R3
  AST_FALLBACK_RC: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (fail_evt && src_status == 2'd1) |=> (src_status == 2'd0 && !en_q[SRC_XTAL])); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (fail_irq && !(wr_ctl && reg_wdata[8])) |=> fail_irq); // R6
  AST_DRIVER_KEPT: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (src_status == 2'd1 && !fail_evt) |=> en_q[SRC_XTAL]); // R8
endmodule

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;
  logic       clk_rc = 1'b0, clk_xtal = 1'b0, clk_pll = 1'b0;
  logic       rst_n = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  logic       sys_clk, fail_irq, clk_out;
  logic [1:0] src_status, pll_ref;
  logic [3:0] pll_mul;

  bit xtal_run = 1'b1, cmp_on = 1'b0;

  sysclk_switch u_dut (
    .clk_rc(clk_rc), .clk_xtal(clk_xtal), .clk_pll(clk_pll), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_clk(sys_clk), .src_status(src_status), .fail_irq(fail_irq), .clk_out(clk_out),
    .pll_ref(pll_ref), .pll_mul(pll_mul)
  );

  always #10 clk_rc = ~clk_rc;   // 50 MHz
  always #4  clk_pll = ~clk_pll;
  always begin
    #6;
    if (xtal_run) clk_xtal = ~clk_xtal;
    else          clk_xtal = 1'b0;
  end

  // reference model state
  int       m_en = 1, m_cur = 0, m_ref = 0, m_mul = 0, m_osel = 0;
  bit       m_mon = 0, m_fail = 0;
  bit [2:0] m_rdy = '0;

  int n_checks = 0, n_err = 0, c_checks = 0, c_err = 0;
  int sys_edges = 0, out_edges = 0;

  always @(posedge sys_clk) sys_edges++;
  always @(posedge clk_out) out_edges++;

  // per-cycle comparison against the model
  always @(negedge clk_rc) begin
    if (cmp_on) begin
      c_checks += 4;
      if (src_status !== 2'(m_cur)) begin
        c_err++; $display("FAIL R1 src_status actual=%0d expected=%0d", src_status, m_cur);
      end
      if (fail_irq !== m_fail) begin
        c_err++; $display("FAIL R6 fail_irq actual=%0d expected=%0d", fail_irq, m_fail);
      end
      if (pll_ref !== 2'(m_ref)) begin
        c_err++; $display("FAIL R9 pll_ref actual=%0d expected=%0d", pll_ref, m_ref);
      end
      if (pll_mul !== 4'(m_mul)) begin
        c_err++; $display("FAIL R9 pll_mul actual=%0d expected=%0d", pll_mul, m_mul);
      end
    end
  end

  function automatic logic [9:0] exp_ctl();
    return {1'b0, m_fail, 1'b0, m_rdy, m_mon, 3'(m_en)};
  endfunction

  function automatic logic [9:0] exp_cfg();
    return {2'(m_osel), 4'(m_mul), 2'(m_ref), 2'(m_cur)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_rc);
  endtask

  task automatic model_write(input bit a, input logic [9:0] d);
    bit [2:0] keep;
    int       nen;
    keep[0] = (m_cur == 0) || (m_cur == 2 && m_ref == 0);
    keep[1] = (m_cur == 1) || (m_cur == 2 && m_ref != 0);
    keep[2] = (m_cur == 2);
    if (!a) begin
      nen = int'(d[2:0] | keep);
      for (int b = 0; b < 3; b++) if (!nen[b]) m_rdy[b] = 1'b0;
      m_en  = nen;
      m_mon = d[3];
      if (d[8]) m_fail = 1'b0;
    end else begin
      if (d[1:0] != 2'd3 && m_rdy[d[1:0]]) m_cur = int'(d[1:0]);
      if (d[3:2] != 2'd3)  m_ref = int'(d[3:2]);
      if (d[7:4] != 4'd15) m_mul = int'(d[7:4]);
      m_osel = int'(d[9:8]);
    end
  endtask

  task automatic wr(input bit a, input logic [9:0] d);
    @(negedge clk_rc);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk_rc);
    #1;
    model_write(a, d);
    @(negedge clk_rc);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input bit a, input string tag);
    logic [9:0] e;
    @(negedge clk_rc);
    reg_addr = a;
    #2;
    e = a ? exp_cfg() : exp_ctl();
    chk(reg_rdata === e, tag, int'(reg_rdata), int'(e));
  endtask

  task automatic meas(input bit use_out, input int exp, input string tag);
    int s0, d;
    @(negedge clk_rc);
    s0 = use_out ? out_edges : sys_edges;
    #2000;
    d = (use_out ? out_edges : sys_edges) - s0;
    chk(d >= exp - 3 && d <= exp + 3, tag, d, exp);
  endtask

  task automatic crystal_dies();
    cmp_on = 1'b0;
    xtal_run = 1'b0;
    idle(40);
    m_fail = 1'b1;
    if (m_cur == 1 || (m_cur == 2 && m_ref != 0)) begin
      m_cur = 0;
      m_en  = m_en | 1;
    end
    m_en     = m_en & ~2;
    m_rdy[1] = 1'b0;
    cmp_on   = 1'b1;
  endtask

  task automatic run_all();
    idle(5);
    rst_n = 1'b1;
    @(negedge clk_rc);
    cmp_on = 1'b1;
    rd_chk(1'b0, "R11 control after reset");
    rd_chk(1'b1, "R11 config after reset");
    idle(40); m_rdy[0] = 1'b1;
    rd_chk(1'b0, "R2 RC ready after settle");
    meas(1'b0, 100, "R1 sys_clk on RC");

    wr(1'b0, 10'h003);
    rd_chk(1'b0, "R2 crystal not ready right after enable");
    wr(1'b1, 10'h001);
    rd_chk(1'b1, "R3 request for unready crystal ignored");
    wr(1'b1, 10'h003);
    rd_chk(1'b1, "R3 request code 3 ignored");
    idle(40); m_rdy[1] = 1'b1;
    rd_chk(1'b0, "R2 crystal ready after settle");
    wr(1'b1, 10'h001);
    rd_chk(1'b1, "R1 crystal selected");
    idle(20);
    meas(1'b0, 166, "R7 sys_clk on crystal");

    wr(1'b0, 10'h002);
    rd_chk(1'b0, "R8 crystal enable kept, R2 RC ready drops at once");
    wr(1'b0, 10'h003);
    idle(40); m_rdy[0] = 1'b1;
    rd_chk(1'b0, "R2 RC ready again");

    wr(1'b1, 10'h075);
    rd_chk(1'b1, "R9 PLL fields written");
    wr(1'b0, 10'h007);
    idle(40); m_rdy[2] = 1'b1;
    wr(1'b1, 10'h076);
    rd_chk(1'b1, "R1 PLL selected");
    idle(20);
    meas(1'b0, 250, "R7 sys_clk on PLL");
    wr(1'b1, 10'h07E);
    rd_chk(1'b1, "R9 reference code 3 ignored");
    wr(1'b1, 10'h0F6);
    rd_chk(1'b1, "R9 multiplier code 15 ignored");
    wr(1'b0, 10'h005);
    rd_chk(1'b0, "R8 PLL reference enable kept");

    wr(1'b1, 10'h376); meas(1'b1, 125, "R10 clk_out PLL/2");
    wr(1'b1, 10'h176); meas(1'b1, 100, "R10 clk_out RC");
    wr(1'b1, 10'h276); meas(1'b1, 166, "R10 clk_out crystal");
    wr(1'b1, 10'h076); meas(1'b1, 250, "R10 clk_out system clock");

    xtal_run = 1'b0;
    idle(40);
    rd_chk(1'b0, "R4 no failure while monitor off");
    xtal_run = 1'b1;
    idle(10);
    wr(1'b0, 10'h00F);
    idle(20);
    rd_chk(1'b0, "R4 no failure while crystal runs");

    crystal_dies();
    rd_chk(1'b0, "R5 fallback from PLL on crystal reference");
    meas(1'b0, 100, "R5 sys_clk back on RC");
    idle(30);
    wr(1'b0, 10'h00D);
    rd_chk(1'b0, "R6 flag sticky without clear bit");
    wr(1'b0, 10'h10D);
    rd_chk(1'b0, "R6 flag cleared by writing one");

    xtal_run = 1'b1;
    idle(5);
    wr(1'b0, 10'h00F);
    idle(40); m_rdy[1] = 1'b1;
    wr(1'b1, 10'h071);
    rd_chk(1'b1, "R1 crystal selected again");
    idle(20);
    meas(1'b0, 166, "R7 sys_clk on crystal again");
    crystal_dies();
    rd_chk(1'b1, "R5 fallback from direct crystal");
    meas(1'b0, 100, "R5 sys_clk on RC after crystal loss");
    wr(1'b0, 10'h10D);
    wr(1'b0, 10'h009);
    rd_chk(1'b0, "R2 PLL ready drops when disabled");
    idle(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 20);
        n_checks++; n_err++;
        $display("FAIL R1 watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", n_checks + c_checks, n_err + c_err);
    $finish;
  end
endmodule